// File: doc/BRIEF.md
# AES Round Key Expansion Unit

This block turns a 128-bit or 256-bit AES cipher key into the complete schedule of 128-bit round keys and keeps them in a small key store. A separate round datapath reads that store by round number. The key always enters on one 256-bit port. A one-bit width select picks the key length. A one-cycle start pulse begins the expansion, and a ready flag tells the datapath when the schedule is complete.

The unit produces one round key per clock. For a 128-bit key, every step applies the rotate, substitute and round-constant transform. For a 256-bit key, the steps alternate between that full transform and a substitute-only transform on successive half-keys. The S-box is computed as a GF(2^8) inverse followed by the affine map, so no lookup table is stored. The round constant starts at 0x01 and is doubled modulo 0x11b each time it is consumed.

Top module: `aes_key_expander`

## Requirements
- R1: A 128-bit key is taken from `keyIn[255:128]`, and `keyIn[127:0]` has no effect on any stored round key. For a 256-bit key, entry 0 holds `keyIn[255:128]` and entry 1 holds `keyIn[127:0]`.
- R2: `keyWide` = 0 selects a 128-bit key, which fills entries 0 to 10. `keyWide` = 1 selects a 256-bit key, which fills entries 0 to 14.
- R3: After expansion, every valid entry equals the standard AES key schedule for the latched key and length (bit 127 of an entry is the most significant bit of its first word).
- R4: When `initStart` is sampled high while `ready` is high, `ready` is low from the next cycle. It stays low for exactly 10 cycles for a 128-bit key and 13 cycles for a 256-bit key, and rises only once the last entry has been written. While `initStart` is low, `ready` stays high.
- R5: An `initStart` pulse that arrives while `ready` is low has no effect. Neither the run length nor any stored entry changes.
- R6: Round keys read from the port drive a standard AES encryption correctly. With key 2b7e151628aed2a6abf7158809cf4f3c, block 6bc1bee22e409f96e93d7e117393172a encrypts to 3ad77bb40d7a3660a89ecaf32466ef97. With key 603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, the same block encrypts to f3eed1bdb5d2a03c064b5a7e3db181f8.
- R7: `rdKey` follows `rdIdx` combinationally. An index above the last valid entry for the latched length (10 or 14) returns all zeros. Before the first expansion after reset, the latched length is 128-bit.
- R8: Driving `rstN` low asynchronously returns the unit to idle with `ready` high, even in the middle of an expansion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| initStart | input | 1 | One-cycle pulse that starts an expansion |
| keyWide | input | 1 | Key length select: 0 = 128-bit, 1 = 256-bit |
| keyIn | input | 256 | Cipher key, left-aligned |
| ready | output | 1 | High when idle and the schedule is complete |
| rdIdx | input | 4 | Round number to read |
| rdKey | output | 128 | Round key for `rdIdx`, or zero if out of range |

## Verification
The assertions assume that `initStart` is a single-cycle pulse and that `keyIn` and `keyWide` are valid in the cycle where that pulse is sampled with `ready` high. They make no assumption about those inputs at any other time. The stimulus changes inputs only on falling edges and holds `initStart` high for exactly one cycle per request. It deliberately pulses `initStart` with a different key and length during a run, and it places junk in the unused half of the key port. This exercises the ignore paths while staying inside those assumptions. The bench reads round keys only while `ready` is high, because during a run the store is only partly updated.

// File: rtl/aes_kx_pkg.sv
`timescale 1ns/1ps
package aes_kx_pkg;
  localparam int BLK_W      = 128;
  localparam int KEY_W      = 2 * BLK_W;
  localparam int WORD_W     = 32;
  localparam int NUM_RK     = 15;
  localparam int RK_IDX_W   = 4;
  localparam int LAST_SHORT = 10;
  localparam int LAST_LONG  = NUM_RK - 1;

  typedef struct packed {
    logic                load;
    logic                step;
    logic                rotate;
    logic                wide;
    logic [RK_IDX_W-1:0] wrIdx;
  } kxCtrl_t;

  function automatic logic [7:0] gfDouble(input logic [7:0] a);
    gfDouble = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction
endpackage

// File: rtl/aes_kx_sbox.sv
`timescale 1ns/1ps
module aes_kx_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import aes_kx_pkg::*;

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gfDouble(sh);
    end
    return acc;
  endfunction

  // a^254 is the multiplicative inverse (0 maps to 0)
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] prod;
    sq   = a;
    prod = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq   = gfMul(sq, sq);
      prod = gfMul(prod, sq);
    end
    return prod;
  endfunction

  logic [7:0] inv;

  always_comb begin
    inv  = gfInv(din);
    dout = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  end
endmodule

// File: rtl/aes_kx_ctrl.sv
`timescale 1ns/1ps
module aes_kx_ctrl
  import aes_kx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                initStart,
  input  logic                keyWide,
  output logic                ready,
  output logic [RK_IDX_W-1:0] lastIdx,
  output kxCtrl_t             strb
);
  typedef enum logic {KX_IDLE, KX_RUN} kxState_e;

  kxState_e            state;
  logic [RK_IDX_W-1:0] roundCnt;
  logic                wideReg;

  assign ready   = (state == KX_IDLE);
  assign lastIdx = wideReg ? RK_IDX_W'(LAST_LONG) : RK_IDX_W'(LAST_SHORT);

  always_comb begin
    strb.load   = ready && initStart;
    strb.step   = (state == KX_RUN);
    strb.wide   = ready ? keyWide : wideReg;
    strb.rotate = !wideReg || !roundCnt[0];
    strb.wrIdx  = roundCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= KX_IDLE;
      roundCnt <= '0;
      wideReg  <= 1'b0;
    end else if (state == KX_IDLE) begin
      if (initStart) begin
        state    <= KX_RUN;
        wideReg  <= keyWide;
        roundCnt <= keyWide ? RK_IDX_W'(2) : RK_IDX_W'(1);
      end
    end else begin
      if (roundCnt == lastIdx) state <= KX_IDLE;
      else roundCnt <= roundCnt + 1'b1;
    end
  end

  // R4: a start accepted while idle drops ready in the next cycle
  a_r4_ready_falls: assert property (@(posedge clk) disable iff (!rstN)
    (ready && initStart) |=> !ready);

  // R5: a running expansion advances by one round every cycle, whatever initStart does
  a_r5_run_advances: assert property (@(posedge clk) disable iff (!rstN)
    (state == KX_RUN && roundCnt != lastIdx) |=>
      (state == KX_RUN && roundCnt == $past(roundCnt) + 1'b1));

  // R2: writes stay within the valid entries of the latched length
  a_r2_write_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (strb.wrIdx >= 1 && strb.wrIdx <= lastIdx));
endmodule

// File: rtl/aes_kx_datapath.sv
`timescale 1ns/1ps
module aes_kx_datapath
  import aes_kx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  kxCtrl_t             strb,
  input  logic [KEY_W-1:0]    keyIn,
  input  logic [RK_IDX_W-1:0] lastIdx,
  input  logic [RK_IDX_W-1:0] rdIdx,
  output logic [BLK_W-1:0]    rdKey
);
  localparam int WORDS = BLK_W / WORD_W;

  logic [BLK_W-1:0]  keyMem [NUM_RK];
  logic [BLK_W-1:0]  olderKey;
  logic [BLK_W-1:0]  newerKey;
  logic [7:0]        rcon;
  logic [WORD_W-1:0] lastWord;
  logic [WORD_W-1:0] subIn;
  logic [WORD_W-1:0] subOut;
  logic [WORD_W-1:0] tWord;
  logic [BLK_W-1:0]  nextKey;

  assign lastWord = newerKey[WORD_W-1:0];
  assign subIn    = strb.rotate ? {lastWord[WORD_W-9:0], lastWord[WORD_W-1 -: 8]} : lastWord;

  for (genvar b = 0; b < WORD_W / 8; b++) begin : g_sbox
    aes_kx_sbox u_sbox (
      .din (subIn[8*b +: 8]),
      .dout(subOut[8*b +: 8])
    );
  end

  assign tWord = subOut ^ (strb.rotate ? {rcon, 24'h000000} : 32'h0);

  always_comb begin
    logic [WORD_W-1:0] acc;
    acc = tWord;
    for (int w = 0; w < WORDS; w++) begin
      acc = acc ^ olderKey[BLK_W-1-WORD_W*w -: WORD_W];
      nextKey[BLK_W-1-WORD_W*w -: WORD_W] = acc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rcon <= 8'h01;
    else if (strb.load) rcon <= 8'h01;
    else if (strb.step && strb.rotate) rcon <= gfDouble(rcon);
  end

  always_ff @(posedge clk) begin
    if (strb.load) begin
      keyMem[0] <= keyIn[KEY_W-1 -: BLK_W];
      if (strb.wide) keyMem[1] <= keyIn[BLK_W-1:0];
      olderKey <= keyIn[KEY_W-1 -: BLK_W];
      newerKey <= strb.wide ? keyIn[BLK_W-1:0] : keyIn[KEY_W-1 -: BLK_W];
    end else if (strb.step) begin
      keyMem[strb.wrIdx] <= nextKey;
      olderKey <= strb.wide ? newerKey : nextKey;
      newerKey <= nextKey;
    end
  end

  assign rdKey = (rdIdx <= lastIdx) ? keyMem[rdIdx] : '0;

  // R3: each full-transform step consumes a fresh, nonzero round constant
  a_r3_rcon_advances: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.rotate) |=> (rcon != $past(rcon) && rcon != 8'h00));
endmodule

// File: rtl/aes_key_expander.sv
`timescale 1ns/1ps
module aes_key_expander
  import aes_kx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                initStart,
  input  logic                keyWide,
  input  logic [KEY_W-1:0]    keyIn,
  output logic                ready,
  input  logic [RK_IDX_W-1:0] rdIdx,
  output logic [BLK_W-1:0]    rdKey
);
  kxCtrl_t             strb;
  logic [RK_IDX_W-1:0] lastIdx;

  aes_kx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .initStart(initStart),
    .keyWide  (keyWide),
    .ready    (ready),
    .lastIdx  (lastIdx),
    .strb     (strb)
  );

  aes_kx_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .keyIn  (keyIn),
    .lastIdx(lastIdx),
    .rdIdx  (rdIdx),
    .rdKey  (rdKey)
  );

  // R4: without a start request, an idle unit stays ready
  a_r4_ready_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !initStart) |=> ready);

  // R7: an index beyond the last valid round always reads zero
  a_r7_oob_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx > lastIdx) |-> (rdKey == '0));
endmodule

// File: tb/aes_key_expander_bench.sv
`timescale 1ns/1ps
module aes_key_expander_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         initStart = 1'b0;
  logic         keyWide = 1'b0;
  logic [255:0] keyIn = '0;
  logic         ready;
  logic [3:0]   rdIdx = '0;
  logic [127:0] rdKey;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]   sbT [256];
  logic [127:0] rk [15];
  logic [127:0] modelRk [15];

  localparam logic [255:0] KEY_A = 256'h2b7e151628aed2a6abf7158809cf4f3c_00000000000000000000000000000000;
  localparam logic [255:0] KEY_B = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
  localparam logic [127:0] PLAIN = 128'h6bc1bee22e409f96e93d7e117393172a;

  localparam logic [127:0] SCHED_A [11] = '{
    128'h2b7e151628aed2a6abf7158809cf4f3c, 128'ha0fafe1788542cb123a339392a6c7605,
    128'hf2c295f27a96b9435935807a7359f67f, 128'h3d80477d4716fe3e1e237e446d7a883b,
    128'hef44a541a8525b7fb671253bdb0bad00, 128'hd4d1c6f87c839d87caf2b8bc11f915bc,
    128'h6d88a37a110b3efddbf98641ca0093fd, 128'h4e54f70e5f5fc9f384a64fb24ea6dc4f,
    128'head27321b58dbad2312bf5607f8d292f, 128'hac7766f319fadc2128d12941575c006e,
    128'hd014f9a8c9ee2589e13f0cc8b6630ca6
  };

  aes_key_expander u_aes_key_expander (
    .clk(clk), .rstN(rstN), .initStart(initStart), .keyWide(keyWide),
    .keyIn(keyIn), .ready(ready), .rdIdx(rdIdx), .rdKey(rdKey)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // S-box from an exp/log walk over generator 3
  task automatic buildSbox();
    logic [7:0] ex [256];
    logic [7:0] lg [256];
    logic [7:0] p;
    logic [7:0] v;
    p = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[i] = p;
      lg[p] = 8'(i);
      p = p ^ xt(p);
    end
    for (int a = 0; a < 256; a++) begin
      v = (a == 0) ? 8'h00 : ex[(255 - int'(lg[a])) % 255];
      sbT[a] = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
    end
  endtask

  function automatic logic [31:0] subW(input logic [31:0] w);
    return {sbT[w[31:24]], sbT[w[23:16]], sbT[w[15:8]], sbT[w[7:0]]};
  endfunction

  task automatic modelExpand(input logic [255:0] key, input bit wide);
    logic [31:0] w [60];
    logic [31:0] t;
    logic [7:0]  rc;
    int nk;
    int total;
    nk    = wide ? 8 : 4;
    total = wide ? 60 : 44;
    rc    = 8'h01;
    for (int i = 0; i < nk; i++) w[i] = key[255-32*i -: 32];
    for (int i = nk; i < total; i++) begin
      t = w[i-1];
      if (i % nk == 0) begin
        t = subW({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = xt(rc);
      end else if (nk == 8 && i % 8 == 4) begin
        t = subW(t);
      end
      w[i] = w[i-nk] ^ t;
    end
    for (int r = 0; r < total / 4; r++) modelRk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] subShift(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(r+4*c) -: 8] = sbT[s[127-8*(r+4*((c+r)%4)) -: 8]];
    return o;
  endfunction

  function automatic logic [127:0] mixCols(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127-32*c -: 8]; a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8]; a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      o[119-32*c -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      o[111-32*c -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      o[103-32*c -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
    return o;
  endfunction

  function automatic logic [127:0] encrypt(input logic [127:0] pt, input int nr);
    logic [127:0] s;
    s = pt ^ rk[0];
    for (int r = 1; r < nr; r++) s = mixCols(subShift(s)) ^ rk[r];
    return subShift(s) ^ rk[nr];
  endfunction

  task automatic readAll();
    for (int i = 0; i < 15; i++) begin
      rdIdx = 4'(i);
      #1;
      rk[i] = rdKey;
    end
  endtask

  // Start an expansion; inject a stray start while busy when injectAt > 0
  task automatic runExpand(input logic [255:0] key, input bit wide, input int injectAt, output int lows);
    @(negedge clk);
    keyIn = key; keyWide = wide; initStart = 1'b1;
    @(negedge clk);
    initStart = 1'b0;
    chk("R4 ready low after start", 128'(ready), 128'd0);
    lows = 0;
    while (!ready && lows < 64) begin
      lows++;
      if (lows == injectAt) begin
        initStart = 1'b1; keyIn = ~key; keyWide = ~wide;
      end else begin
        initStart = 1'b0;
      end
      @(negedge clk);
    end
    initStart = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lows;
    buildSbox();
    #23 rstN = 1'b1;

    // R8 and R7: reset state
    chk("R8 ready after reset", 128'(ready), 128'd1);
    rdIdx = 4'd11; #1;
    chk("R7 idx 11 zero after reset", rdKey, '0);

    // R1, R3, R4: 128-bit key with junk in the low half, walked against the schedule table
    runExpand({KEY_A[255:128], 128'hdeadbeef0badf00dcafef00d12345678}, 1'b0, 0, lows);
    chk("R4 128-bit busy cycles", 128'(lows), 128'd10);
    readAll();
    for (int i = 0; i < 11; i++) chk($sformatf("R3 R1 entry %0d", i), rk[i], SCHED_A[i]);
    for (int i = 11; i < 16; i++) begin
      rdIdx = 4'(i); #1;
      chk($sformatf("R7 idx %0d zero", i), rdKey, '0);
    end
    chk("R6 128-bit encrypt", encrypt(PLAIN, 10), 128'h3ad77bb40d7a3660a89ecaf32466ef97);

    // R2, R3: 256-bit key against the bench model
    runExpand(KEY_B, 1'b1, 0, lows);
    chk("R4 256-bit busy cycles", 128'(lows), 128'd13);
    readAll();
    modelExpand(KEY_B, 1'b1);
    chk("R1 wide entry 1", rk[1], KEY_B[127:0]);
    for (int i = 0; i < 15; i++) chk($sformatf("R2 R3 wide entry %0d", i), rk[i], modelRk[i]);
    rdIdx = 4'd15; #1;
    chk("R7 idx 15 zero wide", rdKey, '0);
    chk("R6 256-bit encrypt", encrypt(PLAIN, 14), 128'hf3eed1bdb5d2a03c064b5a7e3db181f8);

    // R5: stray start during a 128-bit run changes nothing
    runExpand(KEY_A, 1'b0, 3, lows);
    chk("R5 busy cycles unchanged", 128'(lows), 128'd10);
    readAll();
    for (int i = 0; i < 11; i++) chk($sformatf("R5 entry %0d", i), rk[i], SCHED_A[i]);
    rdIdx = 4'd11; #1;
    chk("R5 length not switched", rdKey, '0);

    // R4: ready stays high with no start
    repeat (3) @(negedge clk);
    chk("R4 idle holds ready", 128'(ready), 128'd1);

    // R8: asynchronous reset mid-run
    @(negedge clk); keyIn = KEY_B; keyWide = 1'b1; initStart = 1'b1;
    @(negedge clk); initStart = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 busy before reset", 128'(ready), 128'd0);
    #2 rstN = 1'b0;
    #1 chk("R8 ready async", 128'(ready), 128'd1);
    @(negedge clk); rstN = 1'b1;

    // R3: a clean run after reset still matches
    runExpand(KEY_A, 1'b0, 0, lows);
    readAll();
    chk("R3 last entry after reset", rk[10], SCHED_A[10]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule